// File: doc/BRIEF.md
# Floating-Point Operation Decoder

This block turns one 32-bit instruction word from the floating-point computational major opcode into the control signals an FP execute stage needs. It picks out the operation, the register indices, the rounding-mode field, the precision, and which register file gets the result. It also decides whether the instruction is legal under the current configuration. The configuration is three static enables (single precision, double precision, 64-bit integer width) and the 2-bit FP unit state from the status register.

The block is purely combinational and does no arithmetic. Several operation groups share one primary code and are told apart by a secondary field: the funct3 slot for sign injection, min/max, compares, raw moves and classify, and the rs2 slot for conversions. The decoder checks those secondary fields, the precision enables, the width mode and the FP state. Any instruction that fails a check is flagged illegal, and all of its side-effect outputs are suppressed. Fused multiply-add forms and FP loads and stores are handled elsewhere.

Top module: `fp_op_decoder`

## Requirements
- R1: Only words whose bits [6:0] equal 1010011 are claimed (opfp_hit=1). For any other value, opfp_hit, illegal, op_sel, wr_int, wr_fp and fs_dirty are all 0.
- R2: rd_idx, rs1_idx, rs2_idx and rm_fld always equal instruction bits [11:7], [19:15], [24:20] and [14:12], whatever the opcode.
- R3: When fs_state is 0, every claimed instruction is illegal.
- R4: funct7 bits [1:0] select the format: 00 is single and needs f_en; 01 is double and needs d_en. Codes 10 and 11 are illegal. is_dbl is 1 only for a legal double-format operation.
- R5: op_sel is one-hot with this bit order: 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 sign-inject, 6 sign-inject-negated, 7 sign-inject-xor, 8 min, 9 max, 10 equal, 11 less-than, 12 less-or-equal, 13 FP-to-int, 14 int-to-FP, 15 FP-to-FP, 16 move FP-to-int, 17 move int-to-FP, 18 classify. Exactly one bit is set for a legal instruction and none otherwise.
- R6: funct7[6:2] codes 00000, 00001, 00010 and 00011 give add, sub, mul and div. Code 01011 gives sqrt and needs rs2=0. A code not listed in R6 to R11 is illegal.
- R7: Code 00100 with funct3 0, 1 or 2 gives sign-inject, negated or xor. Code 00101 with funct3 0 or 1 gives min or max. Any other funct3 is illegal.
- R8: Code 10100 with funct3 2 gives equal, 1 gives less-than and 0 gives less-or-equal. Funct3 3 to 7 is illegal.
- R9: Funct7 1100000/1100001 are FP-to-int and 1101000/1101001 are int-to-FP. rs2 values 0 to 3 select signed word, unsigned word, signed long and unsigned long, and cvt_kind reports rs2[1:0]. rs2 above 3 is illegal. Long forms (rs2 2 or 3) are illegal when xlen64=0.
- R10: Funct7 0100000 (double to single) needs rs2=1 and funct7 0100001 (single to double) needs rs2=0. Both need d_en, and is_dbl gives the destination format.
- R11: Code 11100 with funct3 0 is move FP-to-int and with funct3 1 is classify. Code 11110 with funct3 0 is move int-to-FP. All three need rs2=0. Double-format raw moves are illegal when xlen64=0, but double classify is not.
- R12: Compares, FP-to-int conversions, classify and move FP-to-int assert wr_int. Every other legal operation asserts wr_fp, and fs_dirty equals wr_fp.
- R13: While illegal is 1, op_sel, wr_int, wr_fp, fs_dirty, is_dbl and cvt_kind are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| f_en | input | 1 | Single-precision support enabled |
| d_en | input | 1 | Double-precision support enabled |
| xlen64 | input | 1 | 64-bit integer width mode |
| fs_state | input | 2 | FP unit state from the status register; 0 means off |
| op_sel | output | 19 | One-hot operation select |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rm_fld | output | 3 | Rounding-mode / funct3 field |
| is_dbl | output | 1 | Legal operation in double format |
| cvt_kind | output | 2 | Integer type of a conversion |
| wr_int | output | 1 | Result goes to the integer register file |
| wr_fp | output | 1 | Result goes to the FP register file |
| fs_dirty | output | 1 | FP state becomes dirty |
| illegal | output | 1 | Claimed instruction is illegal |
| opfp_hit | output | 1 | Instruction belongs to this opcode |

## Verification
The assertions check the structural properties for every input combination the bench applies:
- op_sel is one-hot, and a legal operation drives exactly one write target;
- an illegal decode stays quiet;
- foreign opcodes are ignored;
- an FP state of off forces illegal;
- raw double moves never appear legal in 32-bit mode;
- an integer-file write never marks the state dirty.

Which operation a given funct7/funct3/rs2 pattern maps to, and each secondary-field rejection, can only be shown by the bench's directed scenarios, which compare each decode against expected values written from the requirements.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int RM_W   = 3;
  localparam int F7_W   = 7;
  localparam int N_OPS  = 19;
  localparam int OP_W   = $clog2(N_OPS);
  localparam logic [6:0] OPC_OPFP = 7'b1010011;

  typedef enum logic [OP_W-1:0] {
    K_ADD   = 5'd0,
    K_SUB   = 5'd1,
    K_MUL   = 5'd2,
    K_DIV   = 5'd3,
    K_SQRT  = 5'd4,
    K_SGNJ  = 5'd5,
    K_SGNJN = 5'd6,
    K_SGNJX = 5'd7,
    K_MIN   = 5'd8,
    K_MAX   = 5'd9,
    K_EQ    = 5'd10,
    K_LT    = 5'd11,
    K_LE    = 5'd12,
    K_F2I   = 5'd13,
    K_I2F   = 5'd14,
    K_F2F   = 5'd15,
    K_MVFX  = 5'd16,
    K_MVXF  = 5'd17,
    K_CLASS = 5'd18
  } fp_op_e;

  // funct7[6:2] group codes
  localparam logic [4:0] G_ADD  = 5'b00000;
  localparam logic [4:0] G_SUB  = 5'b00001;
  localparam logic [4:0] G_MUL  = 5'b00010;
  localparam logic [4:0] G_DIV  = 5'b00011;
  localparam logic [4:0] G_SQRT = 5'b01011;
  localparam logic [4:0] G_SGN  = 5'b00100;
  localparam logic [4:0] G_MNX  = 5'b00101;
  localparam logic [4:0] G_CMP  = 5'b10100;
  localparam logic [4:0] G_F2I  = 5'b11000;
  localparam logic [4:0] G_I2F  = 5'b11010;
  localparam logic [4:0] G_F2F  = 5'b01000;
  localparam logic [4:0] G_MVX  = 5'b11100;
  localparam logic [4:0] G_MVF  = 5'b11110;

  typedef struct packed {
    fp_op_e op;
    logic   enc_ok;
    logic   fmt_ok;
    logic   need64;
    logic   need_d;
    logic   dbl;
  } cls_t;

  // Operations whose result lands in the integer register file.
  function automatic logic op_to_int(input fp_op_e op);
    case (op)
      K_EQ, K_LT, K_LE, K_F2I, K_MVFX, K_CLASS: op_to_int = 1'b1;
      default:                                  op_to_int = 1'b0;
    endcase
  endfunction

  // Conversions between integer and FP carry an integer-type selector.
  function automatic logic op_has_kind(input fp_op_e op);
    op_has_kind = (op == K_F2I) || (op == K_I2F);
  endfunction

  // Primary decode from funct7 / funct3 / rs2 into an operation and its needs.
  function automatic cls_t classify(input logic [F7_W-1:0] f7,
                                    input logic [RM_W-1:0] f3,
                                    input logic [REG_W-1:0] rs2);
    cls_t c;
    logic rs2_zero;
    rs2_zero = (rs2 == '0);
    c.op     = K_ADD;
    c.enc_ok = 1'b0;
    c.fmt_ok = ~f7[1];
    c.need64 = 1'b0;
    c.need_d = f7[0];
    c.dbl    = f7[0];
    case (f7[6:2])
      G_ADD:  begin c.op = K_ADD; c.enc_ok = 1'b1; end
      G_SUB:  begin c.op = K_SUB; c.enc_ok = 1'b1; end
      G_MUL:  begin c.op = K_MUL; c.enc_ok = 1'b1; end
      G_DIV:  begin c.op = K_DIV; c.enc_ok = 1'b1; end
      G_SQRT: begin c.op = K_SQRT; c.enc_ok = rs2_zero; end
      G_SGN: begin
        case (f3)
          3'd0:    begin c.op = K_SGNJ;  c.enc_ok = 1'b1; end
          3'd1:    begin c.op = K_SGNJN; c.enc_ok = 1'b1; end
          3'd2:    begin c.op = K_SGNJX; c.enc_ok = 1'b1; end
          default: c.enc_ok = 1'b0;
        endcase
      end
      G_MNX: begin
        case (f3)
          3'd0:    begin c.op = K_MIN; c.enc_ok = 1'b1; end
          3'd1:    begin c.op = K_MAX; c.enc_ok = 1'b1; end
          default: c.enc_ok = 1'b0;
        endcase
      end
      G_CMP: begin
        case (f3)
          3'd0:    begin c.op = K_LE; c.enc_ok = 1'b1; end
          3'd1:    begin c.op = K_LT; c.enc_ok = 1'b1; end
          3'd2:    begin c.op = K_EQ; c.enc_ok = 1'b1; end
          default: c.enc_ok = 1'b0;
        endcase
      end
      G_F2I, G_I2F: begin
        c.op     = (f7[6:2] == G_F2I) ? K_F2I : K_I2F;
        c.enc_ok = (rs2[REG_W-1:2] == '0);
        c.need64 = rs2[1];
      end
      G_F2F: begin
        c.op     = K_F2F;
        c.enc_ok = (rs2 == {{(REG_W-1){1'b0}}, ~f7[0]});
        c.need_d = 1'b1;
      end
      G_MVX: begin
        c.enc_ok = rs2_zero && (f3 == 3'd0 || f3 == 3'd1);
        c.op     = (f3 == 3'd1) ? K_CLASS : K_MVFX;
        c.need64 = (f3 == 3'd0) && f7[0];
      end
      G_MVF: begin
        c.op     = K_MVXF;
        c.enc_ok = rs2_zero && (f3 == 3'd0);
        c.need64 = f7[0];
      end
      default: c.enc_ok = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fpdec_fields.sv
module fpdec_fields
  import fpdec_pkg::*;
#(
  parameter int IW = INSN_W,
  parameter int RW = REG_W,
  parameter int MW = RM_W
) (
  input  logic [IW-1:0] insn,
  output logic          opc_match,
  output logic [6:0]    funct7,
  output logic [RW-1:0] rd,
  output logic [RW-1:0] rs1,
  output logic [RW-1:0] rs2,
  output logic [MW-1:0] f3
);
  localparam int RD_LO  = 7;
  localparam int F3_LO  = RD_LO + RW;
  localparam int RS1_LO = F3_LO + MW;
  localparam int RS2_LO = RS1_LO + RW;
  localparam int F7_LO  = RS2_LO + RW;

  assign opc_match = (insn[6:0] == OPC_OPFP);
  assign rd        = insn[RD_LO +: RW];
  assign f3        = insn[F3_LO +: MW];
  assign rs1       = insn[RS1_LO +: RW];
  assign rs2       = insn[RS2_LO +: RW];
  assign funct7    = insn[F7_LO +: 7];
endmodule

// File: rtl/fpdec_classify.sv
module fpdec_classify
  import fpdec_pkg::*;
(
  input  logic [F7_W-1:0]  funct7,
  input  logic [RM_W-1:0]  f3,
  input  logic [REG_W-1:0] rs2,
  output cls_t             cls
);
  always_comb cls = classify(funct7, f3, rs2);
endmodule

// File: rtl/fpdec_gate.sv
module fpdec_gate
  import fpdec_pkg::*;
#(
  parameter int NOPS = N_OPS
) (
  input  logic            hit,
  input  logic [1:0]      fs_state,
  input  logic            f_en,
  input  logic            d_en,
  input  logic            xlen64,
  input  cls_t            cls,
  input  logic [1:0]      kind_bits,
  output logic [NOPS-1:0] op_sel,
  output logic            legal,
  output logic            illegal,
  output logic            wr_int,
  output logic            wr_fp,
  output logic            is_dbl,
  output logic [1:0]      cvt_kind
);
  logic fs_on, prec_ok, mode_ok, int_dest;

  assign fs_on    = (fs_state != 2'b00);
  assign prec_ok  = cls.need_d ? d_en : f_en;
  assign mode_ok  = ~cls.need64 | xlen64;
  assign int_dest = op_to_int(cls.op);

  assign legal   = hit & fs_on & cls.enc_ok & cls.fmt_ok & prec_ok & mode_ok;
  assign illegal = hit & ~legal;

  for (genvar i = 0; i < NOPS; i++) begin : g_sel
    assign op_sel[i] = legal && (int'(cls.op) == i);
  end

  assign wr_int   = legal & int_dest;
  assign wr_fp    = legal & ~int_dest;
  assign is_dbl   = legal & cls.dbl;
  assign cvt_kind = (legal && op_has_kind(cls.op)) ? kind_bits : 2'b00;
endmodule

// File: rtl/fp_op_decoder.sv
module fp_op_decoder
  import fpdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              f_en,
  input  logic              d_en,
  input  logic              xlen64,
  input  logic [1:0]        fs_state,
  output logic [N_OPS-1:0]  op_sel,
  output logic [REG_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rs1_idx,
  output logic [REG_W-1:0]  rs2_idx,
  output logic [RM_W-1:0]   rm_fld,
  output logic              is_dbl,
  output logic [1:0]        cvt_kind,
  output logic              wr_int,
  output logic              wr_fp,
  output logic              fs_dirty,
  output logic              illegal,
  output logic              opfp_hit
);
  logic [F7_W-1:0] funct7;
  logic            opc_match;
  logic            legal;
  cls_t            cls;

  fpdec_fields u_fields (
    .insn      (insn),
    .opc_match (opc_match),
    .funct7    (funct7),
    .rd        (rd_idx),
    .rs1       (rs1_idx),
    .rs2       (rs2_idx),
    .f3        (rm_fld)
  );

  fpdec_classify u_cls (
    .funct7 (funct7),
    .f3     (rm_fld),
    .rs2    (rs2_idx),
    .cls    (cls)
  );

  fpdec_gate u_gate (
    .hit       (opc_match),
    .fs_state  (fs_state),
    .f_en      (f_en),
    .d_en      (d_en),
    .xlen64    (xlen64),
    .cls       (cls),
    .kind_bits (rs2_idx[1:0]),
    .op_sel    (op_sel),
    .legal     (legal),
    .illegal   (illegal),
    .wr_int    (wr_int),
    .wr_fp     (wr_fp),
    .is_dbl    (is_dbl),
    .cvt_kind  (cvt_kind)
  );

  assign opfp_hit = opc_match;
  assign fs_dirty = wr_fp & legal;
endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk
  import fpdec_pkg::*;
(
  input logic [INSN_W-1:0] insn,
  input logic              xlen64,
  input logic [1:0]        fs_state,
  input logic [N_OPS-1:0]  op_sel,
  input logic              is_dbl,
  input logic [1:0]        cvt_kind,
  input logic              wr_int,
  input logic              wr_fp,
  input logic              fs_dirty,
  input logic              illegal,
  input logic              opfp_hit
);
  always_comb begin
    assert_sel_onehot0_R5: assert ($onehot0(op_sel))
      else $error("op_sel not one-hot");
    if (insn[6:0] != OPC_OPFP) begin
      assert_foreign_quiet_R1: assert (!opfp_hit && !illegal && op_sel == '0 && !wr_int && !wr_fp)
        else $error("foreign opcode produced a decode");
    end
    if (opfp_hit && fs_state == 2'b00) begin
      assert_fs_off_R3: assert (illegal)
        else $error("decode legal with FP off");
    end
    if (illegal) begin
      assert_illegal_quiet_R13: assert (op_sel == '0 && !wr_int && !wr_fp && !fs_dirty && !is_dbl && cvt_kind == 2'b00)
        else $error("illegal decode has side effects");
    end
    if (opfp_hit && !illegal) begin
      assert_one_target_R12: assert (wr_int ^ wr_fp)
        else $error("legal decode lacks a single write target");
      assert_sel_exact_R5: assert ($countones(op_sel) == 1)
        else $error("legal decode lacks an operation");
    end
    if (wr_int) begin
      assert_int_clean_R12: assert (!fs_dirty)
        else $error("integer write marked FP dirty");
    end
    if (!xlen64 && (op_sel[K_MVFX] || op_sel[K_MVXF])) begin
      assert_narrow_move_R11: assert (!is_dbl)
        else $error("double raw move accepted in 32-bit mode");
    end
  end
endmodule

bind fp_op_decoder fpdec_chk u_chk (
  .insn     (insn),
  .xlen64   (xlen64),
  .fs_state (fs_state),
  .op_sel   (op_sel),
  .is_dbl   (is_dbl),
  .cvt_kind (cvt_kind),
  .wr_int   (wr_int),
  .wr_fp    (wr_fp),
  .fs_dirty (fs_dirty),
  .illegal  (illegal),
  .opfp_hit (opfp_hit)
);

// File: tb/sim_fp_op_decoder.sv
module sim_fp_op_decoder;
  localparam int NO = 19;
  localparam int O_ADD = 0, O_SUB = 1, O_MUL = 2, O_DIV = 3, O_SQRT = 4;
  localparam int O_SJ = 5, O_SJN = 6, O_SJX = 7, O_MIN = 8, O_MAX = 9;
  localparam int O_EQ = 10, O_LT = 11, O_LE = 12, O_F2I = 13, O_I2F = 14;
  localparam int O_F2F = 15, O_MVFX = 16, O_MVXF = 17, O_CLS = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0]   insn = '0;
  logic          f_en = 1'b0, d_en = 1'b0, xlen64 = 1'b0;
  logic [1:0]    fs_state = 2'b00;
  logic [NO-1:0] op_sel;
  logic [4:0]    rd_idx, rs1_idx, rs2_idx;
  logic [2:0]    rm_fld;
  logic          is_dbl, wr_int, wr_fp, fs_dirty, illegal, opfp_hit;
  logic [1:0]    cvt_kind;

  fp_op_decoder u0 (
    .insn(insn), .f_en(f_en), .d_en(d_en), .xlen64(xlen64), .fs_state(fs_state),
    .op_sel(op_sel), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rm_fld(rm_fld), .is_dbl(is_dbl), .cvt_kind(cvt_kind), .wr_int(wr_int),
    .wr_fp(wr_fp), .fs_dirty(fs_dirty), .illegal(illegal), .opfp_hit(opfp_hit)
  );

  typedef struct {
    logic [31:0] w;
    bit          hit;
    bit          ill;
    int          op;
    bit          intd;
    bit          dbl;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                     input logic [4:0] r1, input logic [2:0] f3,
                                     input logic [4:0] rd);
    return {f7, r2, r1, f3, rd, 7'b1010011};
  endfunction

  // Driver: applies one word and configuration, pushes the expectation.
  task automatic drive(input logic [31:0] w, input bit fe, input bit de, input bit x64,
                       input logic [1:0] fs, input bit eh, input bit ei, input int eop,
                       input bit eint, input bit edbl, input string req);
    exp_t e;
    @(posedge clk);
    insn = w; f_en = fe; d_en = de; xlen64 = x64; fs_state = fs;
    e.w = w; e.hit = eh; e.ill = ei; e.op = eop; e.intd = eint; e.dbl = edbl; e.req = req;
    sb.push_back(e);
  endtask

  // Legal decode in the default configuration.
  task automatic ok_op(input logic [31:0] w, input int eop, input bit eint,
                       input bit edbl, input string req);
    drive(w, 1, 1, 1, 2'b11, 1, 0, eop, eint, edbl, req);
  endtask

  task automatic bad(input logic [31:0] w, input bit fe, input bit de, input bit x64,
                     input logic [1:0] fs, input string req);
    drive(w, fe, de, x64, fs, 1, 1, -1, 0, 0, req);
  endtask

  // Monitor: compares the oldest expectation away from the driving edge.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      logic [NO-1:0] ev;
      bit legal;
      logic [1:0] ek;
      e = sb.pop_front();
      legal = e.hit && !e.ill;
      ev = '0;
      if (legal && e.op >= 0) ev[e.op] = 1'b1;
      ek = (legal && (e.op == O_F2I || e.op == O_I2F)) ? e.w[21:20] : 2'b00;
      chk(opfp_hit == e.hit, e.req, "hit", 64'(opfp_hit), 64'(e.hit));
      chk(illegal == e.ill, e.req, "illegal", 64'(illegal), 64'(e.ill));
      chk(op_sel == ev, e.req, "op_sel", 64'(op_sel), 64'(ev));
      chk(wr_int == (legal && e.intd), e.req, "wr_int", 64'(wr_int), 64'(legal && e.intd));
      chk(wr_fp == (legal && !e.intd), e.req, "wr_fp", 64'(wr_fp), 64'(legal && !e.intd));
      chk(fs_dirty == (legal && !e.intd), e.req, "fs_dirty", 64'(fs_dirty), 64'(legal && !e.intd));
      chk(is_dbl == (legal && e.dbl), e.req, "is_dbl", 64'(is_dbl), 64'(legal && e.dbl));
      chk(cvt_kind == ek, e.req, "cvt_kind", 64'(cvt_kind), 64'(ek));
      chk({rd_idx, rs1_idx, rs2_idx, rm_fld} == {e.w[11:7], e.w[19:15], e.w[24:20], e.w[14:12]},
          "R2", "fields", 64'({rd_idx, rs1_idx, rs2_idx, rm_fld}),
          64'({e.w[11:7], e.w[19:15], e.w[24:20], e.w[14:12]}));
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: idle word, nothing claimed (R1)
    chk(opfp_hit == 0 && illegal == 0 && op_sel == '0 && !wr_int && !wr_fp && !fs_dirty,
        "R1", "reset idle", 64'({opfp_hit, illegal, wr_int, wr_fp}), 64'd0);
    rst = 1'b0;

    // R1: foreign major opcode ignored even with odd secondary fields
    drive({7'b0000000, 5'd3, 5'd4, 3'd1, 5'd7, 7'b0110011}, 1, 1, 1, 2'b11, 0, 0, -1, 0, 0, "R1");
    drive({7'b1100001, 5'd9, 5'd4, 3'd7, 5'd7, 7'b1010111}, 1, 1, 1, 2'b00, 0, 0, -1, 0, 0, "R1");

    // R6: arithmetic group, R2 field extraction
    ok_op(mk(7'b0000000, 5'd17, 5'd9, 3'd3, 5'd5), O_ADD, 0, 0, "R6");
    ok_op(mk(7'b0000101, 5'd1, 5'd30, 3'd7, 5'd31), O_SUB, 0, 1, "R6");
    ok_op(mk(7'b0001000, 5'd2, 5'd3, 3'd0, 5'd4), O_MUL, 0, 0, "R6");
    ok_op(mk(7'b0001101, 5'd2, 5'd3, 3'd1, 5'd4), O_DIV, 0, 1, "R6");
    ok_op(mk(7'b0101101, 5'd0, 5'd8, 3'd2, 5'd1), O_SQRT, 0, 1, "R6");
    bad(mk(7'b0101100, 5'd3, 5'd8, 3'd2, 5'd1), 1, 1, 1, 2'b11, "R6");
    bad(mk(7'b0110000, 5'd0, 5'd8, 3'd0, 5'd1), 1, 1, 1, 2'b11, "R6");

    // R7: sign injection and min/max
    ok_op(mk(7'b0010000, 5'd6, 5'd6, 3'd0, 5'd2), O_SJ, 0, 0, "R7");
    ok_op(mk(7'b0010001, 5'd6, 5'd7, 3'd1, 5'd2), O_SJN, 0, 1, "R7");
    ok_op(mk(7'b0010000, 5'd6, 5'd7, 3'd2, 5'd2), O_SJX, 0, 0, "R7");
    bad(mk(7'b0010000, 5'd6, 5'd7, 3'd3, 5'd2), 1, 1, 1, 2'b11, "R7");
    ok_op(mk(7'b0010100, 5'd1, 5'd2, 3'd0, 5'd3), O_MIN, 0, 0, "R7");
    ok_op(mk(7'b0010101, 5'd1, 5'd2, 3'd1, 5'd3), O_MAX, 0, 1, "R7");
    bad(mk(7'b0010101, 5'd1, 5'd2, 3'd2, 5'd3), 1, 1, 1, 2'b11, "R7");

    // R8 / R12: compares write the integer file
    ok_op(mk(7'b1010001, 5'd4, 5'd5, 3'd2, 5'd6), O_EQ, 1, 1, "R8");
    ok_op(mk(7'b1010000, 5'd4, 5'd5, 3'd1, 5'd6), O_LT, 1, 0, "R8");
    ok_op(mk(7'b1010000, 5'd4, 5'd5, 3'd0, 5'd6), O_LE, 1, 0, "R12");
    bad(mk(7'b1010000, 5'd4, 5'd5, 3'd3, 5'd6), 1, 1, 1, 2'b11, "R8");

    // R9: integer conversions and the long forms
    ok_op(mk(7'b1100000, 5'd0, 5'd1, 3'd1, 5'd2), O_F2I, 1, 0, "R9");
    ok_op(mk(7'b1100001, 5'd1, 5'd1, 3'd1, 5'd2), O_F2I, 1, 1, "R9");
    ok_op(mk(7'b1100000, 5'd2, 5'd1, 3'd1, 5'd2), O_F2I, 1, 0, "R9");
    ok_op(mk(7'b1100001, 5'd3, 5'd1, 3'd1, 5'd2), O_F2I, 1, 1, "R9");
    bad(mk(7'b1100000, 5'd4, 5'd1, 3'd1, 5'd2), 1, 1, 1, 2'b11, "R9");
    bad(mk(7'b1100000, 5'd2, 5'd1, 3'd1, 5'd2), 1, 1, 0, 2'b11, "R9");
    drive(mk(7'b1100000, 5'd1, 5'd1, 3'd1, 5'd2), 1, 1, 0, 2'b11, 1, 0, O_F2I, 1, 0, "R9");
    ok_op(mk(7'b1101001, 5'd3, 5'd9, 3'd0, 5'd10), O_I2F, 0, 1, "R9");
    ok_op(mk(7'b1101000, 5'd1, 5'd9, 3'd0, 5'd10), O_I2F, 0, 0, "R9");
    bad(mk(7'b1101001, 5'd3, 5'd9, 3'd0, 5'd10), 1, 1, 0, 2'b01, "R9");

    // R10: precision-changing conversions
    ok_op(mk(7'b0100000, 5'd1, 5'd3, 3'd0, 5'd4), O_F2F, 0, 0, "R10");
    bad(mk(7'b0100000, 5'd0, 5'd3, 3'd0, 5'd4), 1, 1, 1, 2'b11, "R10");
    ok_op(mk(7'b0100001, 5'd0, 5'd3, 3'd0, 5'd4), O_F2F, 0, 1, "R10");
    bad(mk(7'b0100001, 5'd1, 5'd3, 3'd0, 5'd4), 1, 1, 1, 2'b11, "R10");
    bad(mk(7'b0100000, 5'd1, 5'd3, 3'd0, 5'd4), 1, 0, 1, 2'b11, "R10");

    // R11: raw moves and classify
    drive(mk(7'b1110000, 5'd0, 5'd3, 3'd0, 5'd4), 1, 1, 0, 2'b01, 1, 0, O_MVFX, 1, 0, "R11");
    bad(mk(7'b1110001, 5'd0, 5'd3, 3'd0, 5'd4), 1, 1, 0, 2'b11, "R11");
    ok_op(mk(7'b1110001, 5'd0, 5'd3, 3'd0, 5'd4), O_MVFX, 1, 1, "R11");
    drive(mk(7'b1110001, 5'd0, 5'd3, 3'd1, 5'd4), 1, 1, 0, 2'b11, 1, 0, O_CLS, 1, 1, "R11");
    bad(mk(7'b1110000, 5'd1, 5'd3, 3'd0, 5'd4), 1, 1, 1, 2'b11, "R11");
    bad(mk(7'b1110000, 5'd0, 5'd3, 3'd2, 5'd4), 1, 1, 1, 2'b11, "R11");
    bad(mk(7'b1111001, 5'd0, 5'd3, 3'd0, 5'd4), 1, 1, 0, 2'b11, "R11");
    ok_op(mk(7'b1111001, 5'd0, 5'd3, 3'd0, 5'd4), O_MVXF, 0, 1, "R11");
    drive(mk(7'b1111000, 5'd0, 5'd3, 3'd0, 5'd4), 1, 1, 0, 2'b10, 1, 0, O_MVXF, 0, 0, "R12");
    bad(mk(7'b1111000, 5'd0, 5'd3, 3'd1, 5'd4), 1, 1, 1, 2'b11, "R11");

    // R3: FP unit off
    bad(mk(7'b0000000, 5'd1, 5'd2, 3'd0, 5'd3), 1, 1, 1, 2'b00, "R3");
    bad(mk(7'b1010001, 5'd1, 5'd2, 3'd2, 5'd3), 1, 1, 1, 2'b00, "R3");

    // R4: format versus enables
    bad(mk(7'b0000000, 5'd1, 5'd2, 3'd0, 5'd3), 0, 1, 1, 2'b11, "R4");
    drive(mk(7'b0000001, 5'd1, 5'd2, 3'd0, 5'd3), 0, 1, 1, 2'b11, 1, 0, O_ADD, 0, 1, "R4");
    bad(mk(7'b0000001, 5'd1, 5'd2, 3'd0, 5'd3), 1, 0, 1, 2'b11, "R4");
    bad(mk(7'b0000010, 5'd1, 5'd2, 3'd0, 5'd3), 1, 1, 1, 2'b11, "R4");
    bad(mk(7'b1010011, 5'd1, 5'd2, 3'd0, 5'd3), 1, 1, 1, 2'b11, "R13");

    // R5: walk back to a plain op after an illegal one
    ok_op(mk(7'b0001000, 5'd0, 5'd0, 3'd0, 5'd0), O_MUL, 0, 0, "R5");

    wait (sb.size() == 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule